// File: doc/BRIEF.md
# Locked Atomic Memory Arbiter

This block lets several processor-side request ports share one memory port. Each requester presents a request (opcode, address, operand, compare value and a lock bit) under a valid/ready handshake. Requests are served one at a time, and a requester's `req_ready_o` bit pulses in the cycle its last memory beat completes. One cycle later the block returns a done pulse and the response data.

Plain reads and writes use one memory beat. Read-modify-write opcodes run as an indivisible pair: first a read beat, then a write beat of a value that the built-in ALU computes from the old word. A bus lock flag covers the whole pair. While the flag is up, the memory port stays with the owning requester and every other requester waits with its request still pending. The owner's interrupt-ready bit stays low until the locked work ends.

A requester can also extend the lock past one transaction by setting its lock bit, so that an operand split over several words is accessed with no other requester in between. Unlocked traffic is shared round-robin.

Top module: `atomic_mem_arbiter`

## Requirements
- R1: Opcode 0 (read) and opcode 1 (write) each use exactly one memory beat. The requester's ready bit is high in the cycle that beat completes. `rsp_done_o` for that requester pulses in the next cycle, with `rsp_rdata_o` holding the read word (zero for a write).
- R2: Opcodes 2 (swap), 3 (add), 4 (AND), 5 (OR) and 6 (XOR) make one read beat and then one write beat to the same address. The word written is the operand, the old word plus the operand (modulo 2^DW), or the old word ANDed, ORed or XORed with the operand.
- R3: Opcode 7 (compare-exchange) writes the operand only when the word read equals the compare value. On a mismatch no write beat occurs and memory is unchanged.
- R4: Every read-modify-write opcode returns the word read before modification as its response data.
- R5: `bus_lock_o` is high from the cycle of the read beat of a read-modify-write until its write beat completes. It is low in the following cycle unless the request's lock bit was set.
- R6: While `bus_lock_o` is high, no other requester gets ready or memory access. Its request stays pending and is served after the lock drops.
- R7: A swap is always locked, even when its lock bit is 0.
- R8: `irq_ready_o` is low for the lock owner while `bus_lock_o` is high, and high for every requester otherwise.
- R9: A completed access with the lock bit set keeps the lock and the grant for the same requester. Other requesters wait until that requester completes an access with the lock bit clear.
- R10: When unlocked, the arbiter grants the first valid requester at or after a pointer. The pointer moves to one past the granted requester when that requester releases the bus.
- R11: While `rst_ni` is low and after its release: no lock, no grant, no memory request, no ready or done, and all interrupt-ready bits high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | N_MST | Request valid per requester |
| req_ready_o | output | N_MST | Request accepted (final beat completes) |
| req_op_i | input | 3*N_MST | Opcode per requester |
| req_lock_i | input | N_MST | Keep lock after this access |
| req_addr_i | input | AW*N_MST | Word address per requester |
| req_wdata_i | input | DW*N_MST | Write data or ALU operand |
| req_cmp_i | input | DW*N_MST | Compare value for compare-exchange |
| rsp_done_o | output | N_MST | Response pulse per requester |
| rsp_rdata_o | output | DW | Response data |
| irq_ready_o | output | N_MST | Requester may take an interrupt |
| bus_lock_o | output | 1 | Bus lock flag |
| mem_valid_o | output | 1 | Memory beat request |
| mem_ready_i | input | 1 | Memory beat completes this cycle |
| mem_we_o | output | 1 | Beat is a write |
| mem_addr_o | output | AW | Memory address |
| mem_wdata_o | output | DW | Memory write data |
| mem_rdata_i | input | DW | Memory read data, valid with mem_ready_i |

## Verification
A request seen valid at a rising edge is granted at that edge. Its first memory beat is visible in the following cycle, and `bus_lock_o` and the owner's interrupt-ready bit change at that same grant edge. The ready bit rises in the cycle of the final beat, and the done pulse with its data appears exactly one cycle after the completing edge. The bench drives and samples only on falling edges. It waits for ready at a falling edge and reads done and data at the next falling edge. Memory stalls are held in place so that lock, stall and interrupt-ready states can be checked at fixed cycles inside a locked sequence.

// File: rtl/atomic_arb_pkg.sv
package atomic_arb_pkg;

  typedef enum logic [2:0] {
    OP_RD   = 3'd0,
    OP_WR   = 3'd1,
    OP_SWAP = 3'd2,
    OP_ADD  = 3'd3,
    OP_AND  = 3'd4,
    OP_OR   = 3'd5,
    OP_XOR  = 3'd6,
    OP_CAS  = 3'd7
  } arb_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_XFER,
    ST_RD,
    ST_WR
  } arb_st_e;

  function automatic logic op_is_rmw(arb_op_e op);
    return (op >= OP_SWAP);
  endfunction

endpackage

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int N_MST = 3,
  localparam int IW = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input  logic [N_MST-1:0] req_i,
  input  logic [IW-1:0]    ptr_i,
  output logic             vld_o,
  output logic [IW-1:0]    idx_o
);

  int cand;

  always_comb begin
    vld_o = 1'b0;
    idx_o = '0;
    cand  = 0;
    for (int k = 0; k < N_MST; k++) begin
      cand = (int'(ptr_i) + k) % N_MST;
      if (!vld_o && req_i[cand]) begin
        vld_o = 1'b1;
        idx_o = IW'(cand);
      end
    end
  end

endmodule

// File: rtl/arb_rmw_alu.sv
module arb_rmw_alu
  import atomic_arb_pkg::*;
#(
  parameter int DW = 32
) (
  input  arb_op_e       op_i,
  input  logic [DW-1:0] old_i,
  input  logic [DW-1:0] opnd_i,
  input  logic [DW-1:0] cmp_i,
  output logic [DW-1:0] new_o,
  output logic          wr_en_o
);

  always_comb begin
    unique case (op_i)
      OP_SWAP: new_o = opnd_i;
      OP_ADD:  new_o = old_i + opnd_i;
      OP_AND:  new_o = old_i & opnd_i;
      OP_OR:   new_o = old_i | opnd_i;
      OP_XOR:  new_o = old_i ^ opnd_i;
      OP_CAS:  new_o = opnd_i;
      default: new_o = old_i;
    endcase
    wr_en_o = (op_i == OP_CAS) ? (old_i == cmp_i) : 1'b1;
  end

endmodule

// File: rtl/atomic_mem_arbiter.sv
module atomic_mem_arbiter
  import atomic_arb_pkg::*;
#(
  parameter int N_MST = 3,
  parameter int DW    = 32,
  parameter int AW    = 8,
  localparam int IW   = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_MST-1:0]   req_valid_i,
  output logic [N_MST-1:0]   req_ready_o,
  input  logic [N_MST*3-1:0] req_op_i,
  input  logic [N_MST-1:0]   req_lock_i,
  input  logic [N_MST*AW-1:0] req_addr_i,
  input  logic [N_MST*DW-1:0] req_wdata_i,
  input  logic [N_MST*DW-1:0] req_cmp_i,
  output logic [N_MST-1:0]   rsp_done_o,
  output logic [DW-1:0]      rsp_rdata_o,
  output logic [N_MST-1:0]   irq_ready_o,
  output logic               bus_lock_o,
  output logic               mem_valid_o,
  input  logic               mem_ready_i,
  output logic               mem_we_o,
  output logic [AW-1:0]      mem_addr_o,
  output logic [DW-1:0]      mem_wdata_o,
  input  logic [DW-1:0]      mem_rdata_i
);

  arb_st_e         state_q;
  logic [IW-1:0]   gnt_q, ptr_q, ptr_nxt;
  logic            lock_q;
  logic [DW-1:0]   old_q, rdata_q;
  logic [N_MST-1:0] done_q;

  arb_op_e         op_a   [N_MST];
  logic [AW-1:0]   addr_a [N_MST];
  logic [DW-1:0]   wdat_a [N_MST];
  logic [DW-1:0]   cmp_a  [N_MST];
  logic [N_MST-1:0] own_oh;

  for (genvar g = 0; g < N_MST; g++) begin : g_unpack
    assign op_a[g]   = arb_op_e'(req_op_i[g*3 +: 3]);
    assign addr_a[g] = req_addr_i[g*AW +: AW];
    assign wdat_a[g] = req_wdata_i[g*DW +: DW];
    assign cmp_a[g]  = req_cmp_i[g*DW +: DW];
    assign own_oh[g] = (gnt_q == IW'(g));
  end

  arb_op_e       sel_op;
  logic [AW-1:0] sel_addr;
  logic [DW-1:0] sel_wdat, sel_cmp;
  logic          sel_lock;

  assign sel_op   = op_a[gnt_q];
  assign sel_addr = addr_a[gnt_q];
  assign sel_wdat = wdat_a[gnt_q];
  assign sel_cmp  = cmp_a[gnt_q];
  assign sel_lock = req_lock_i[gnt_q];

  // while locked only the owner may be picked
  logic [N_MST-1:0] pick_req;
  logic             pick_vld;
  logic [IW-1:0]    pick_idx;

  assign pick_req = lock_q ? (req_valid_i & own_oh) : req_valid_i;

  arb_rr_pick #(.N_MST(N_MST)) u_pick (
    .req_i (pick_req),
    .ptr_i (ptr_q),
    .vld_o (pick_vld),
    .idx_o (pick_idx)
  );

  logic [DW-1:0] alu_old, alu_new;
  logic          alu_wr_en;

  assign alu_old = (state_q == ST_RD) ? mem_rdata_i : old_q;

  arb_rmw_alu #(.DW(DW)) u_alu (
    .op_i    (sel_op),
    .old_i   (alu_old),
    .opnd_i  (sel_wdat),
    .cmp_i   (sel_cmp),
    .new_o   (alu_new),
    .wr_en_o (alu_wr_en)
  );

  logic          beat, done_now;
  logic [DW-1:0] rdata_now;

  always_comb begin
    mem_valid_o = (state_q != ST_IDLE);
    mem_we_o    = (state_q == ST_WR) || ((state_q == ST_XFER) && (sel_op == OP_WR));
    mem_addr_o  = sel_addr;
    mem_wdata_o = (state_q == ST_WR) ? alu_new : sel_wdat;
    beat        = mem_valid_o && mem_ready_i;
    unique case (state_q)
      ST_XFER: done_now = beat;
      ST_RD:   done_now = beat && !alu_wr_en;  // compare miss ends early
      ST_WR:   done_now = beat;
      default: done_now = 1'b0;
    endcase
    unique case (state_q)
      ST_XFER: rdata_now = (sel_op == OP_RD) ? mem_rdata_i : '0;
      ST_RD:   rdata_now = mem_rdata_i;
      default: rdata_now = old_q;
    endcase
  end

  assign ptr_nxt     = (gnt_q == IW'(N_MST - 1)) ? '0 : gnt_q + 1'b1;
  assign req_ready_o = done_now ? own_oh : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      gnt_q   <= '0;
      ptr_q   <= '0;
      lock_q  <= 1'b0;
      old_q   <= '0;
      rdata_q <= '0;
      done_q  <= '0;
    end else begin
      done_q <= req_ready_o;
      if (done_now) rdata_q <= rdata_now;
      unique case (state_q)
        ST_IDLE: begin
          if (pick_vld) begin
            gnt_q   <= pick_idx;
            state_q <= op_is_rmw(op_a[pick_idx]) ? ST_RD : ST_XFER;
            lock_q  <= lock_q | op_is_rmw(op_a[pick_idx]) | req_lock_i[pick_idx];
          end
        end
        ST_RD: begin
          if (beat) begin
            old_q <= mem_rdata_i;
            if (alu_wr_en) state_q <= ST_WR;
          end
        end
        default: ;
      endcase
      if (done_now) begin
        state_q <= ST_IDLE;
        lock_q  <= sel_lock;
        if (!sel_lock) ptr_q <= ptr_nxt;
      end
    end
  end

  for (genvar g = 0; g < N_MST; g++) begin : g_irq
    assign irq_ready_o[g] = !(lock_q && own_oh[g]);
  end

  assign bus_lock_o  = lock_q;
  assign rsp_done_o  = done_q;
  assign rsp_rdata_o = rdata_q;

endmodule

// File: rtl/atomic_mem_arbiter_chk.sv
module atomic_mem_arbiter_chk #(
  parameter int N_MST = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_MST-1:0] req_valid_i,
  input logic [N_MST-1:0] req_ready_o,
  input logic [N_MST-1:0] rsp_done_o,
  input logic [N_MST-1:0] irq_ready_o,
  input logic             bus_lock_o,
  input logic             mem_valid_o,
  input logic             mem_ready_i,
  input logic             mem_we_o
);

  AST_READ_THEN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_lock_o && mem_valid_o && mem_ready_i && !mem_we_o && (req_ready_o == '0))
      |=> (bus_lock_o && mem_valid_o && mem_we_o)); // R2

  AST_LOCK_STALLS_OTHERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_lock_o |-> ((req_ready_o & irq_ready_o) == '0)); // R6

  AST_READY_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o & ~req_valid_i) == '0); // R6

  AST_IRQ_FREE_UNLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_lock_o |-> (&irq_ready_o)); // R8

  AST_IRQ_ONE_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_lock_o |-> ($countones(~irq_ready_o) == 1)); // R8

  AST_DONE_AFTER_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_ready_o) |=> (rsp_done_o == $past(req_ready_o))); // R1

  AST_SINGLE_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(req_ready_o)); // R10

endmodule

bind atomic_mem_arbiter atomic_mem_arbiter_chk #(.N_MST(N_MST)) u_chk (.*);

// File: tb/tb_atomic_mem_arbiter.sv
module tb_atomic_mem_arbiter;

  localparam int CLK_PERIOD = 10;
  localparam int NM = 3;
  localparam int DW = 32;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [NM-1:0]    m_valid = '0;
  logic [NM-1:0]    m_lock = '0;
  logic [2:0]       m_op   [NM];
  logic [AW-1:0]    m_addr [NM];
  logic [DW-1:0]    m_wdat [NM];
  logic [DW-1:0]    m_cmp  [NM];

  logic [NM*3-1:0]  req_op;
  logic [NM*AW-1:0] req_addr;
  logic [NM*DW-1:0] req_wdata, req_cmp;

  for (genvar g = 0; g < NM; g++) begin : g_pack
    assign req_op[g*3 +: 3]     = m_op[g];
    assign req_addr[g*AW +: AW] = m_addr[g];
    assign req_wdata[g*DW +: DW] = m_wdat[g];
    assign req_cmp[g*DW +: DW]  = m_cmp[g];
  end

  logic [NM-1:0] req_ready_o, rsp_done_o, irq_ready_o;
  logic [DW-1:0] rsp_rdata_o, mem_wdata_o, mem_rdata_i;
  logic          bus_lock_o, mem_valid_o, mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic          mem_rdy = 1'b1;

  atomic_mem_arbiter #(.N_MST(NM), .DW(DW), .AW(AW)) dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .req_valid_i (m_valid),
    .req_ready_o (req_ready_o),
    .req_op_i    (req_op),
    .req_lock_i  (m_lock),
    .req_addr_i  (req_addr),
    .req_wdata_i (req_wdata),
    .req_cmp_i   (req_cmp),
    .rsp_done_o  (rsp_done_o),
    .rsp_rdata_o (rsp_rdata_o),
    .irq_ready_o (irq_ready_o),
    .bus_lock_o  (bus_lock_o),
    .mem_valid_o (mem_valid_o),
    .mem_ready_i (mem_rdy),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rdata_i (mem_rdata_i)
  );

  // memory model, word i starts at 0x100+i
  logic [DW-1:0] mem_m [16];
  int wr_cnt;
  assign mem_rdata_i = mem_m[mem_addr_o[3:0]];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem_m[i] <= 32'h100 + i;
      wr_cnt <= 0;
    end else if (mem_valid_o && mem_rdy && mem_we_o) begin
      mem_m[mem_addr_o[3:0]] <= mem_wdata_o;
      wr_cnt <= wr_cnt + 1;
    end
  end

  int n_chk = 0;
  int n_err = 0;
  int ord [8];
  int n_ord = 0;

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_op(input int m, input logic [2:0] op, input logic [AW-1:0] a,
                       input logic [DW-1:0] wd, input logic [DW-1:0] cmp,
                       input logic lk, output logic [DW-1:0] rd);
    @(negedge clk);
    m_op[m] = op; m_addr[m] = a; m_wdat[m] = wd; m_cmp[m] = cmp;
    m_lock[m] = lk; m_valid[m] = 1'b1;
    do @(negedge clk); while (!req_ready_o[m]);
    @(negedge clk);
    chk("R1 done pulse", {31'b0, rsp_done_o[m]}, 32'd1);
    rd = rsp_rdata_o;
    m_valid[m] = 1'b0;
    ord[n_ord] = m;
    n_ord++;
  endtask

  // {op, addr, operand, compare, exp rdata, exp mem word, exp write beats}
  localparam logic [139:0] VEC [10] = '{
    {3'd0, 8'h02, 32'h0,        32'h0,   32'h102,      32'h102,      1'b0},
    {3'd1, 8'h03, 32'hAAAA5555, 32'h0,   32'h0,        32'hAAAA5555, 1'b1},
    {3'd2, 8'h03, 32'h12345678, 32'h0,   32'hAAAA5555, 32'h12345678, 1'b1},
    {3'd3, 8'h04, 32'h10,       32'h0,   32'h104,      32'h114,      1'b1},
    {3'd4, 8'h03, 32'h0000FFFF, 32'h0,   32'h12345678, 32'h00005678, 1'b1},
    {3'd5, 8'h05, 32'hF0000000, 32'h0,   32'h105,      32'hF0000105, 1'b1},
    {3'd6, 8'h05, 32'hFFFFFFFF, 32'h0,   32'hF0000105, 32'h0FFFFEFA, 1'b1},
    {3'd7, 8'h04, 32'h0000CAFE, 32'h114, 32'h114,      32'h0000CAFE, 1'b1},
    {3'd7, 8'h04, 32'h0000BEEF, 32'h114, 32'h0000CAFE, 32'h0000CAFE, 1'b0},
    {3'd3, 8'h06, 32'hFFFFFFFF, 32'h0,   32'h106,      32'h105,      1'b1}
  };

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [DW-1:0] r0, r1, r2;
    for (int i = 0; i < NM; i++) begin
      m_op[i] = '0; m_addr[i] = '0; m_wdat[i] = '0; m_cmp[i] = '0;
    end
    repeat (3) @(negedge clk);
    chk("R11 lock in reset", {31'b0, bus_lock_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 lock", {31'b0, bus_lock_o}, 32'd0);
    chk("R11 mem_valid", {31'b0, mem_valid_o}, 32'd0);
    chk("R11 ready", {29'b0, req_ready_o}, 32'd0);
    chk("R11 done", {29'b0, rsp_done_o}, 32'd0);
    chk("R11 irq_ready", {29'b0, irq_ready_o}, 32'd7);

    // table walk on requester 0
    for (int v = 0; v < 10; v++) begin
      logic [2:0]    op;
      logic [AW-1:0] a;
      logic [DW-1:0] wd, cp, er, em;
      logic          ew;
      int            wc0;
      string         tag;
      {op, a, wd, cp, er, em, ew} = VEC[v];
      tag = (op < 3'd2) ? "R1" : (op == 3'd7) ? "R3" : "R2";
      wc0 = wr_cnt;
      do_op(0, op, a, wd, cp, 1'b0, r0);
      chk((op < 3'd2) ? "R1 rdata" : "R4 old value", r0, er);
      chk({tag, " memory word"}, mem_m[a[3:0]], em);
      chk({tag, " write beats"}, 32'(wr_cnt - wc0), {31'b0, ew});
    end

    // swap with lock bit clear, memory stalled
    @(negedge clk);
    mem_rdy = 1'b0;
    m_op[0] = 3'd2; m_addr[0] = 8'h0A; m_wdat[0] = 32'h5A5A; m_lock[0] = 1'b0;
    m_valid[0] = 1'b1;
    @(negedge clk);
    chk("R7 swap locked", {31'b0, bus_lock_o}, 32'd1);
    chk("R5 lock at read", {31'b0, bus_lock_o}, 32'd1);
    chk("R8 irq owner low", {29'b0, irq_ready_o}, 32'd6);
    chk("R2 read beat first", {30'b0, mem_valid_o, mem_we_o}, 32'd2);
    m_op[1] = 3'd0; m_addr[1] = 8'h0A; m_lock[1] = 1'b0; m_valid[1] = 1'b1;
    @(negedge clk);
    chk("R6 others stalled", {29'b0, req_ready_o}, 32'd0);
    mem_rdy = 1'b1;
    @(negedge clk);
    chk("R5 lock at write", {30'b0, bus_lock_o, mem_we_o}, 32'd3);
    chk("R8 irq held", {29'b0, irq_ready_o}, 32'd6);
    chk("R6 no ready for waiter", {31'b0, req_ready_o[1]}, 32'd0);
    chk("R7 swap data", mem_wdata_o, 32'h5A5A);
    @(negedge clk);
    m_valid[0] = 1'b0;
    chk("R5 lock released", {31'b0, bus_lock_o}, 32'd0);
    chk("R8 irq free", {29'b0, irq_ready_o}, 32'd7);
    chk("R7 swap returns old", rsp_rdata_o, 32'h10A);
    do @(negedge clk); while (!req_ready_o[1]);
    @(negedge clk);
    m_valid[1] = 1'b0;
    chk("R6 waiter served after", rsp_rdata_o, 32'h5A5A);

    // lock held over two accesses by requester 0
    fork
      begin
        do_op(0, 3'd0, 8'h08, 32'h0, 32'h0, 1'b1, r0);
        chk("R9 first access data", r0, 32'h108);
        repeat (2) begin
          @(negedge clk);
          chk("R9 lock kept", {31'b0, bus_lock_o}, 32'd1);
          chk("R9 other waits", {31'b0, req_ready_o[1]}, 32'd0);
          chk("R8 owner irq low", {31'b0, irq_ready_o[0]}, 32'd0);
        end
        do_op(0, 3'd1, 8'h09, 32'hDEADBEEF, 32'h0, 1'b0, r0);
      end
      begin
        do_op(1, 3'd0, 8'h09, 32'h0, 32'h0, 1'b0, r1);
      end
    join
    chk("R9 other sees locked write", r1, 32'hDEADBEEF);

    // round robin: pointer sits at requester 2
    n_ord = 0;
    fork
      do_op(0, 3'd0, 8'h01, 32'h0, 32'h0, 1'b0, r0);
      do_op(1, 3'd0, 8'h02, 32'h0, 32'h0, 1'b0, r1);
      do_op(2, 3'd0, 8'h0B, 32'h0, 32'h0, 1'b0, r2);
    join
    chk("R10 first grant", 32'(ord[0]), 32'd2);
    chk("R10 second grant", 32'(ord[1]), 32'd0);
    chk("R10 third grant", 32'(ord[2]), 32'd1);
    chk("R10 data m0", r0, 32'h101);
    chk("R10 data m1", r1, 32'h102);
    chk("R10 data m2", r2, 32'h10B);

    @(negedge clk);
    chk("R1 done single pulse", {29'b0, rsp_done_o}, 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule